// File: doc/BRIEF.md
# Dual-Bank IRQ/FIQ Interrupt Controller

This block gathers forty level-sensitive interrupt lines and presents them to a processor on two outputs: a normal interrupt line and a fast interrupt line. Each source has its own enable bit and its own steering bit, and the steering bit picks which of the two lines the source drives. The lines are stored in two banks. Sources 0 to 31 form the low bank and sources 32 to 39 form the high bank. Each bank has its own copy of every per-source register.

There is no latching. A source's pending bit is simply its input level, and software clears an interrupt at the peripheral. A word-wide register port gives software access to several views of the sources. It can read the raw levels, the enable mask and the steering bits. It can also read two filtered views: one lists the enabled sources steered to the normal line, the other lists the enabled sources steered to the fast line. An idle-control bit sets the wake policy while the core is halted. With the bit clear, any pending source raises the wake request. With the bit set, only enabled sources do.

The block also holds a table of forty priority entries. Each entry keeps a valid flag and a six-bit source number. The block only stores the table; a separate block reads it and performs the highest-priority search. The interrupt and wake outputs are registered. Reads are combinational from the address.

Top module: `irq_fiq_intc`

## Requirements
- R1: Source i with i < 32 maps to low-bank bit i. Source i with i >= 32 maps to high-bank bit i-32.
- R2: The raw-pending reads return the current input levels in the same cycle, with nothing latched. Offset 0x10 gives the low bank and offset 0xAC gives the high bank.
- R3: The normal-line filtered views return pending AND enable AND NOT steer, at 0x00 (low bank) and 0x9C (high bank). The fast-line filtered views return pending AND enable AND steer, at 0x0C (low bank) and 0xA8 (high bank). Writes to any of these four offsets change nothing.
- R4: One cycle after a change, `irqOut` is high exactly when some enabled pending source has its steer bit clear. On the same timing, `fiqOut` is high exactly when some enabled pending source has its steer bit set.
- R5: The enable masks are read/write at 0x04 (low bank) and 0xA0 (high bank). The steer registers are read/write at 0x08 (low bank) and 0xA4 (high bank). A steer bit of 1 selects the fast line.
- R6: Offset 0x14 bit 0 is the idle policy. A value of 1 means only enabled sources wake the core, and 0 means any pending source wakes it. A read of 0x14 returns the stored bit in bit 0.
- R7: One cycle after the inputs, `wakeReq` equals `coreHalted` AND a non-zero value of (pending AND (enable OR policy-is-0)), taken across both banks.
- R8: Priority entry k sits at 0x1C+4k for k < 32 and at 0xB0+4(k-32) for k >= 32. A write keeps only bit 31 and bits 5:0, and a read returns zero in bits 30:6.
- R9: Reset clears both masks, both steer registers, the idle bit and every priority entry, and drives all three outputs low.
- R10: A read from an unmapped or misaligned offset returns 0, and so does a read from 0x18, which is reserved for the external highest-priority lookup. A write to any of these is ignored.
- R11: The high-bank registers hold bits 7:0 only. Their upper bits read as 0, and written upper bits are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srcLevel | input | 40 | Interrupt source levels, bit i is source i |
| coreHalted | input | 1 | High while the core sits in idle |
| busAddr | input | 8 | Byte offset of the register access |
| busWrEn | input | 1 | Write strobe for the current cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Normal interrupt request, registered |
| fiqOut | output | 1 | Fast interrupt request, registered |
| wakeReq | output | 1 | Wake request while halted, registered |

## Verification
The bench steers one source to each line and raises another source that is pending but disabled. This catches a design that swaps the filtered views, or that lets a masked source reach `irqOut` or `fiqOut`. It writes all ones to the high-bank mask and writes to the read-only views and to an unmapped offset. A design that drops the bank width or decodes too loosely would then show upper bits or a corrupted mask. The bench flips the idle policy while the core is halted with only a masked source pending. An inverted policy bit would then give the wrong wake level. It also samples `irqOut` in the cycle an input rises, to catch outputs that are combinational instead of registered.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int BANK_W  = 32;
  localparam int IDX_W   = 6;
  localparam int PRIO_W  = IDX_W + 1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IRQ,
    SEL_MASK,
    SEL_STEER,
    SEL_FIQ,
    SEL_RAW,
    SEL_IDLE,
    SEL_PRIO
  } regKindT;

  typedef struct packed {
    regKindT          kind;
    logic             bankHi;
    logic [IDX_W-1:0] idx;
  } regSelT;

  typedef struct packed {
    logic             wrMask;
    logic             wrSteer;
    logic             wrIdle;
    logic             wrPrio;
    logic             bankHi;
    logic [IDX_W-1:0] idx;
  } ctrlStrobeT;

endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_SRC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctrlStrobeT        strobe,
  output regSelT            rdSel
);

  localparam int HI_W         = NUM_SRC - BANK_W;
  localparam int PRIO_LO_BASE = 'h1C;
  localparam int PRIO_LO_LAST = PRIO_LO_BASE + 4 * (BANK_W - 1);
  localparam int HI_BASE      = PRIO_LO_LAST + 4;
  localparam int HI_LAST      = HI_BASE + 4 * 4;
  localparam int PRIO_HI_BASE = HI_LAST + 4;
  localparam int PRIO_HI_LAST = PRIO_HI_BASE + 4 * (HI_W - 1);

  function automatic regSelT decodeAddr(input logic [ADDR_W-1:0] a);
    regSelT     s;
    logic [31:0] v;
    logic [31:0] off;
    s      = '0;
    s.kind = SEL_NONE;
    v      = 32'(a);
    off    = '0;
    if (a[1:0] == 2'b00) begin
      if (v < 32'h18) begin
        case (v[4:2])
          3'd0:    s.kind = SEL_IRQ;
          3'd1:    s.kind = SEL_MASK;
          3'd2:    s.kind = SEL_STEER;
          3'd3:    s.kind = SEL_FIQ;
          3'd4:    s.kind = SEL_RAW;
          3'd5:    s.kind = SEL_IDLE;
          default: s.kind = SEL_NONE;
        endcase
      end else if (v >= 32'(PRIO_LO_BASE) && v <= 32'(PRIO_LO_LAST)) begin
        off    = (v - 32'(PRIO_LO_BASE)) >> 2;
        s.kind = SEL_PRIO;
        s.idx  = off[IDX_W-1:0];
      end else if (v >= 32'(HI_BASE) && v <= 32'(HI_LAST)) begin
        off      = (v - 32'(HI_BASE)) >> 2;
        s.bankHi = 1'b1;
        case (off[2:0])
          3'd0:    s.kind = SEL_IRQ;
          3'd1:    s.kind = SEL_MASK;
          3'd2:    s.kind = SEL_STEER;
          3'd3:    s.kind = SEL_FIQ;
          default: s.kind = SEL_RAW;
        endcase
      end else if (v >= 32'(PRIO_HI_BASE) && v <= 32'(PRIO_HI_LAST)) begin
        off    = ((v - 32'(PRIO_HI_BASE)) >> 2) + 32'(BANK_W);
        s.kind = SEL_PRIO;
        s.idx  = off[IDX_W-1:0];
      end
    end
    return s;
  endfunction

  regSelT decoded;

  always_comb begin
    decoded        = decodeAddr(busAddr);
    rdSel          = decoded;
    strobe.wrMask  = busWrEn && (decoded.kind == SEL_MASK);
    strobe.wrSteer = busWrEn && (decoded.kind == SEL_STEER);
    strobe.wrIdle  = busWrEn && (decoded.kind == SEL_IDLE);
    strobe.wrPrio  = busWrEn && (decoded.kind == SEL_PRIO);
    strobe.bankHi  = decoded.bankHi;
    strobe.idx     = decoded.idx;
  end

  // R8: a priority strobe never points past the last table entry
  assert_prio_idx_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrPrio |-> (32'(strobe.idx) < 32'(NUM_SRC)));

  // R10: a misaligned offset never produces a write strobe
  assert_misaligned_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr[1:0] != 2'b00) |->
      !(strobe.wrMask || strobe.wrSteer || strobe.wrIdle || strobe.wrPrio));

endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic               coreHalted,
  input  logic [31:0]        busWrData,
  input  ctrlStrobeT         strobe,
  input  regSelT             rdSel,
  output logic [31:0]        busRdData,
  output logic               irqOut,
  output logic               fiqOut,
  output logic               wakeReq
);

  localparam int HI_W = NUM_SRC - BANK_W;

  logic [BANK_W-1:0] pendLo, maskLo, steerLo, irqViewLo, fiqViewLo;
  logic [HI_W-1:0]   pendHi, maskHi, steerHi, irqViewHi, fiqViewHi;
  logic              idleEnOnly;
  logic [PRIO_W-1:0] prioTab [NUM_SRC];
  logic              anyIrq, anyFiq, anyWake;
  logic [PRIO_W-1:0] prioSel;

  assign pendLo = srcLevel[BANK_W-1:0];
  assign pendHi = srcLevel[NUM_SRC-1:BANK_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      maskLo     <= '0;
      maskHi     <= '0;
      steerLo    <= '0;
      steerHi    <= '0;
      idleEnOnly <= 1'b0;
    end else begin
      if (strobe.wrMask && !strobe.bankHi)  maskLo  <= busWrData;
      if (strobe.wrMask && strobe.bankHi)   maskHi  <= busWrData[HI_W-1:0];
      if (strobe.wrSteer && !strobe.bankHi) steerLo <= busWrData;
      if (strobe.wrSteer && strobe.bankHi)  steerHi <= busWrData[HI_W-1:0];
      if (strobe.wrIdle)                    idleEnOnly <= busWrData[0];
    end
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_prio
    logic [PRIO_W-1:0] entry;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entry <= '0;
      end else if (strobe.wrPrio && (strobe.idx == IDX_W'(k))) begin
        entry <= {busWrData[31], busWrData[IDX_W-1:0]};
      end
    end
    assign prioTab[k] = entry;
  end

  assign irqViewLo = pendLo & maskLo & ~steerLo;
  assign fiqViewLo = pendLo & maskLo & steerLo;
  assign irqViewHi = pendHi & maskHi & ~steerHi;
  assign fiqViewHi = pendHi & maskHi & steerHi;

  always_comb begin
    anyIrq  = |{irqViewLo, irqViewHi};
    anyFiq  = |{fiqViewLo, fiqViewHi};
    anyWake = |{pendLo & (maskLo | {BANK_W{!idleEnOnly}}),
                pendHi & (maskHi | {HI_W{!idleEnOnly}})};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irqOut  <= 1'b0;
      fiqOut  <= 1'b0;
      wakeReq <= 1'b0;
    end else begin
      irqOut  <= anyIrq;
      fiqOut  <= anyFiq;
      wakeReq <= coreHalted && anyWake;
    end
  end

  assign prioSel = prioTab[rdSel.idx];

  always_comb begin
    case (rdSel.kind)
      SEL_IRQ:   busRdData = rdSel.bankHi ? 32'(irqViewHi) : irqViewLo;
      SEL_FIQ:   busRdData = rdSel.bankHi ? 32'(fiqViewHi) : fiqViewLo;
      SEL_MASK:  busRdData = rdSel.bankHi ? 32'(maskHi)    : maskLo;
      SEL_STEER: busRdData = rdSel.bankHi ? 32'(steerHi)   : steerLo;
      SEL_RAW:   busRdData = rdSel.bankHi ? 32'(pendHi)    : pendLo;
      SEL_IDLE:  busRdData = 32'(idleEnOnly);
      SEL_PRIO:  busRdData = {prioSel[PRIO_W-1], {(32-PRIO_W){1'b0}},
                              prioSel[IDX_W-1:0]};
      default:   busRdData = '0;
    endcase
  end

  // R4: fast line follows the enabled, fast-steered sources one cycle later
  assert_fiq_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fiqOut == $past(|{fiqViewLo, fiqViewHi}));

  // R4: normal line follows the enabled, normal-steered sources one cycle later
  assert_irq_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut == $past(|{irqViewLo, irqViewHi}));

  // R7: no wake request unless the core was halted on the previous edge
  assert_wake_needs_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wakeReq |-> $past(coreHalted));

  // R8: priority reads carry nothing in the unused middle bits
  assert_prio_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdSel.kind == SEL_PRIO) |-> (busRdData[30:IDX_W] == '0));

  // R10: unmapped offsets read as zero
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rdSel.kind == SEL_NONE) |-> (busRdData == '0));

  // R11: high-bank registers show nothing above their width
  assert_hi_bank_narrow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rdSel.bankHi && rdSel.kind != SEL_NONE) |-> (busRdData[31:HI_W] == '0));

endmodule

// File: rtl/irq_fiq_intc.sv
module irq_fiq_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic               coreHalted,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  output logic               irqOut,
  output logic               fiqOut,
  output logic               wakeReq
);

  ctrlStrobeT strobe;
  regSelT     rdSel;

  intc_ctrl #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  intc_datapath #(.NUM_SRC(NUM_SRC)) i_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .srcLevel   (srcLevel),
    .coreHalted (coreHalted),
    .busWrData  (busWrData),
    .strobe     (strobe),
    .rdSel      (rdSel),
    .busRdData  (busRdData),
    .irqOut     (irqOut),
    .fiqOut     (fiqOut),
    .wakeReq    (wakeReq)
  );

endmodule

// File: tb/test_irq_fiq_intc.sv
`timescale 1ns/1ps
module test_irq_fiq_intc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] srcLevel = '0;
  logic        coreHalted = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqOut, fiqOut, wakeReq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_fiq_intc i_irq_fiq_intc (
    .clk(clk), .rst_n(rst_n), .srcLevel(srcLevel), .coreHalted(coreHalted),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .irqOut(irqOut), .fiqOut(fiqOut), .wakeReq(wakeReq)
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  wAddr;
    logic [31:0] wData;
    logic [39:0] src;
    logic        halt;
    logic [7:0]  rAddr;
    logic [31:0] expRd;
    logic        expIrq;
    logic        expFiq;
    logic        expWake;
    logic [7:0]  req;
  } vecT;

  localparam int NVEC = 17;
  localparam vecT VEC [NVEC] = '{
    // R9: mask reads zero, no output
    '{1'b0, 8'h00, 32'h0,        40'h0,           1'b0, 8'h04, 32'h0,        1'b0, 1'b0, 1'b0, 8'd9},
    // R3: enable bits 7:0, source 0 on normal line
    '{1'b1, 8'h04, 32'h000000FF, 40'h1,           1'b0, 8'h00, 32'h1,        1'b1, 1'b0, 1'b0, 8'd3},
    // R5: steer source 0 to fast line
    '{1'b1, 8'h08, 32'h1,        40'h1,           1'b0, 8'h0C, 32'h1,        1'b0, 1'b1, 1'b0, 8'd5},
    // R4: both lines at once
    '{1'b0, 8'h00, 32'h0,        40'h3,           1'b0, 8'h00, 32'h2,        1'b1, 1'b1, 1'b0, 8'd4},
    // R11: high mask keeps 8 bits
    '{1'b1, 8'hA0, 32'hFFFFFF05, 40'h0,           1'b0, 8'hA0, 32'h5,        1'b0, 1'b0, 1'b0, 8'd11},
    // R1: source 32 is high-bank bit 0
    '{1'b0, 8'h00, 32'h0,        40'h01_00000000, 1'b0, 8'h9C, 32'h1,        1'b1, 1'b0, 1'b0, 8'd1},
    // R3: high-bank fast view
    '{1'b1, 8'hA4, 32'h4,        40'h04_00000000, 1'b0, 8'hA8, 32'h4,        1'b0, 1'b1, 1'b0, 8'd3},
    // R2: masked source shows in raw view only
    '{1'b0, 8'h00, 32'h0,        40'h02_00000000, 1'b0, 8'hAC, 32'h2,        1'b0, 1'b0, 1'b0, 8'd2},
    // R7: halted, policy 0, masked source wakes
    '{1'b0, 8'h00, 32'h0,        40'h02_00000000, 1'b1, 8'h14, 32'h0,        1'b0, 1'b0, 1'b1, 8'd7},
    // R6: policy 1, masked source no longer wakes
    '{1'b1, 8'h14, 32'h1,        40'h02_00000000, 1'b1, 8'h14, 32'h1,        1'b0, 1'b0, 1'b0, 8'd6},
    // R6: policy 1, enabled source wakes
    '{1'b0, 8'h00, 32'h0,        40'h1,           1'b1, 8'h10, 32'h1,        1'b0, 1'b1, 1'b1, 8'd6},
    // R8: low-bank entry 1 keeps bit 31 and 5:0
    '{1'b1, 8'h20, 32'hFFFFFFFF, 40'h0,           1'b0, 8'h20, 32'h8000003F, 1'b0, 1'b0, 1'b0, 8'd8},
    // R8: last high-bank entry
    '{1'b1, 8'hCC, 32'h80000027, 40'h0,           1'b0, 8'hCC, 32'h80000027, 1'b0, 1'b0, 1'b0, 8'd8},
    // R10: unmapped offset
    '{1'b1, 8'hD0, 32'hFFFFFFFF, 40'h0,           1'b0, 8'hD0, 32'h0,        1'b0, 1'b0, 1'b0, 8'd10},
    // R10: reserved highest-priority slot
    '{1'b0, 8'h00, 32'h0,        40'h0,           1'b0, 8'h18, 32'h0,        1'b0, 1'b0, 1'b0, 8'd10},
    // R3: write to low filtered view leaves mask alone
    '{1'b1, 8'h00, 32'hFFFFFFFF, 40'h0,           1'b0, 8'h04, 32'hFF,       1'b0, 1'b0, 1'b0, 8'd3},
    // R3: write to high filtered view leaves high mask alone
    '{1'b1, 8'h9C, 32'hFFFFFFFF, 40'h0,           1'b0, 8'hA0, 32'h5,        1'b0, 1'b0, 1'b0, 8'd3}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic readCheck(input string req, input logic [7:0] a,
                           input logic [31:0] exp);
    busAddr = a;
    #1;
    check(req, $sformatf("read 0x%h", a), busRdData, exp);
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    readCheck("R9", 8'h04, 32'h0);
    readCheck("R9", 8'h08, 32'h0);
    readCheck("R9", 8'hA0, 32'h0);
    readCheck("R9", 8'hA4, 32'h0);
    readCheck("R9", 8'h14, 32'h0);
    readCheck("R9", 8'h1C, 32'h0);
    readCheck("R9", 8'hCC, 32'h0);
    check("R9", "irqOut", 32'(irqOut), 32'h0);
    check("R9", "fiqOut", 32'(fiqOut), 32'h0);
    check("R9", "wakeReq", 32'(wakeReq), 32'h0);

    for (int n = 0; n < NVEC; n++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[n].req);
      @(negedge clk);
      srcLevel   = VEC[n].src;
      coreHalted = VEC[n].halt;
      busAddr    = VEC[n].wAddr;
      busWrData  = VEC[n].wData;
      busWrEn    = VEC[n].we;
      @(negedge clk);
      busWrEn = 1'b0;
      @(negedge clk);
      readCheck(tag, VEC[n].rAddr, VEC[n].expRd);
      check(tag, $sformatf("vec %0d irqOut", n), 32'(irqOut), 32'(VEC[n].expIrq));
      check(tag, $sformatf("vec %0d fiqOut", n), 32'(fiqOut), 32'(VEC[n].expFiq));
      check(tag, $sformatf("vec %0d wakeReq", n), 32'(wakeReq), 32'(VEC[n].expWake));
    end

    // R2 and R4: raw view is immediate, irqOut lags one edge
    @(negedge clk);
    srcLevel = 40'h2;
    readCheck("R2", 8'h10, 32'h2);
    check("R4", "irqOut before edge", 32'(irqOut), 32'h0);
    @(negedge clk);
    check("R4", "irqOut after edge", 32'(irqOut), 32'h1);

    // R1: source 39 lands in high-bank bit 7
    regWrite(8'hA0, 32'h80);
    srcLevel = 40'h80_00000000;
    readCheck("R1", 8'hAC, 32'h80);
    readCheck("R1", 8'h10, 32'h0);
    @(negedge clk);
    check("R1", "irqOut from source 39", 32'(irqOut), 32'h1);

    // R10: misaligned read
    readCheck("R10", 8'h06, 32'h0);

    // R9: second reset clears written state, policy returns to 0
    srcLevel = '0;
    doReset();
    readCheck("R9", 8'h04, 32'h0);
    readCheck("R9", 8'h20, 32'h0);
    readCheck("R9", 8'h14, 32'h0);
    coreHalted = 1'b1;
    srcLevel = 40'h20;
    @(negedge clk);
    check("R9", "wake after reset policy", 32'(wakeReq), 32'h1);
    check("R9", "irqOut masked", 32'(irqOut), 32'h0);
    coreHalted = 1'b0;
    @(negedge clk);
    check("R7", "wake drops when awake", 32'(wakeReq), 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule